// File: doc/BRIEF.md
# Boundary Scan Data Register with Partial Cells

This block is the data register that sits between a test access port controller and the pads of a chip. It covers a configurable list of pins. Each pin is declared as bidirectional, input-only or output-only. A bidirectional or output-only pin owns three scan cells: a sampled-input cell, a driven-value cell and an output-enable cell. An input-only pin owns only the sampled-input cell. Every cell has a shift stage. The driven-value and enable cells also have an update latch behind the shift stage.

The TAP controller sends four strobes, all sampled on the rising edge of `tck`: capture, shift, update, and a test-mode level. On capture, each shift stage loads the value it observes. On shift, the register moves one position toward `tdo`. On update, the latches copy their shift stages. While test mode is high, each pad's driven value and enable come from the latches. While it is low, they pass straight through from the core. Instruction decode and the TAP state machine belong to other blocks.

The pin list sets the position of every bit in the register. Pin 0 sits nearest `tdo` and the last pin nearest `tdi`. Inside a pin, the order from `tdo` is sampled input, then driven value, then enable.

Top module: `bscan_chain`

## Requirements
- R1: The register length is three bits per bidirectional or output-only pin plus one bit per input-only pin. The default list gives 11 bits, so a bit entering at `tdi` reaches `tdo` after exactly that many shift edges. Pin kinds are encoded as 0 = bidirectional, 1 = input-only, 2 = output-only.
- R2: Within a driving pin, the three bits sit at base, base+1 and base+2, holding the sampled input, the driven value and the enable. Pins are stacked from pin 0 at bit 0 upward.
- R3: An input-only pin holds only its sampled-input bit. Its `pad_out` and `pad_oe` bits are always 0, in either mode.
- R4: On a capture edge, each sampled-input cell loads `pad_in`. Each driven-value cell loads `core_out` and each enable cell loads `core_oe` for its pin.
- R5: On each rising `tck` edge with shift asserted and capture low, every stage takes the value of its upstream neighbour. The top stage takes `tdi`. `tdo` always shows stage 0.
- R6: Update latches keep their value on every edge without update, including while shifting.
- R7: With `extest` high, a driving pin's `pad_out` and `pad_oe` equal its driven-value and enable latches. With `extest` low, they equal `core_out` and `core_oe`. The enable is active high.
- R8: When capture and shift are asserted on the same edge, capture wins.
- R9: When capture and update are asserted on the same edge, the latches take the shift contents from before the edge, and the stages take the captured values.
- R10: A low `rst_n` on a rising edge clears every stage and every latch.
- R11: On an edge with neither capture nor shift, every stage holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture strobe from the TAP controller |
| shf_en | input | 1 | Shift strobe from the TAP controller |
| upd_en | input | 1 | Update strobe from the TAP controller |
| extest | input | 1 | Test mode: pads are driven from the update latches |
| tdi | input | 1 | Serial data entering the top of the register |
| tdo | output | 1 | Serial data leaving bit 0 |
| pad_in | input | NUM_PINS | Value observed at each pad |
| core_out | input | NUM_PINS | Value the core wants driven on each pad |
| core_oe | input | NUM_PINS | Output enable the core requests for each pad |
| pad_out | output | NUM_PINS | Value presented to each pad driver |
| pad_oe | output | NUM_PINS | Active-high enable presented to each pad driver |

## Verification
Capture can coincide with update on one edge, and it can also coincide with shift. The bench provokes both. It raises capture and update in the same cycle, then checks that the pads show the pattern that was shifted in earlier, not the new samples. It then shifts the register out and expects the freshly captured values. For capture together with shift, the stream that follows must hold the captured values with no one-position offset.

// File: rtl/bsr_pkg.sv
// Package: shared pin-kind encoding and cell counting for the scan register.
// Assumes pin kinds are packed two bits per pin, with pin 0 in the low bits.
package bsr_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        PK_BIDIR   = 2'd0,
        PK_INONLY  = 2'd1,
        PK_OUTONLY = 2'd2
    } pin_kind_e;

    // Number of scan cells a pin of the given kind contributes.
    function automatic int cells_for(logic [KIND_W-1:0] kind);
        return (kind == PK_INONLY) ? 1 : 3;
    endfunction

endpackage

// File: rtl/bsr_cell.sv
// Module: one capture/shift stage of the scan register.
// Loads cap_val on capture, which takes priority over shift.
// Loads si on shift. Otherwise it holds.
// Assumes a synchronous active-low reset and that all strobes are qualified on tck.
module bsr_cell (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic cap_val,
    input  logic si,
    output logic stage_q
);

    // Stage register: reset, capture, shift or hold.
    always_ff @(posedge tck) begin
        if (!rst_n)
            stage_q <= 1'b0;
        else if (cap_en)
            stage_q <= cap_val;
        else if (shf_en)
            stage_q <= si;
    end

    // R4: a capture edge loads the observed value
    a_r4_capture_load: assert property (@(posedge tck) disable iff (!rst_n)
        cap_en |=> stage_q == $past(cap_val));

    // R8: capture wins over a simultaneous shift
    a_r8_capture_over_shift: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_en && shf_en) |=> stage_q == $past(cap_val));

    // R5: a shift edge takes the upstream value
    a_r5_shift_step: assert property (@(posedge tck) disable iff (!rst_n)
        (!cap_en && shf_en) |=> stage_q == $past(si));

    // R11: the stage is quiet without capture or shift
    a_r11_stage_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (!cap_en && !shf_en) |=> $stable(stage_q));

endmodule

// File: rtl/bsr_pin.sv
// Module: the scan cells and pad muxing for one pin.
// A driving pin (bidirectional or output-only) chains its cells si -> enable -> driven value -> sampled input -> so.
// Its driven-value and enable cells also have update latches.
// An input-only pin has the sampled-input cell alone and never drives its pad.
// Assumes KIND holds one of the bsr_pkg pin-kind codes.
module bsr_pin #(
    parameter logic [bsr_pkg::KIND_W-1:0] KIND = bsr_pkg::PK_BIDIR
) (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic extest,
    input  logic si,
    output logic so,
    input  logic pad_in,
    input  logic core_out,
    input  logic core_oe,
    output logic pad_out,
    output logic pad_oe
);
    import bsr_pkg::*;

    generate
        if (KIND == PK_INONLY) begin : g_in_only
            logic unused_in_only;

            // The single sampled-input cell forms the whole pin segment.
            bsr_cell u_in (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .cap_val(pad_in), .si(si), .stage_q(so)
            );

            // Pad driver stays off; the strobes and core values have no role here.
            assign pad_out = 1'b0;
            assign pad_oe  = 1'b0;
            assign unused_in_only = ^{upd_en, extest, core_out, core_oe};
        end else begin : g_drive
            logic oe_stage, out_stage;
            logic oe_lat, out_lat;

            // Enable cell: nearest tdi within this pin.
            bsr_cell u_oe (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .cap_val(core_oe), .si(si), .stage_q(oe_stage)
            );

            // Driven-value cell: middle of the pin.
            bsr_cell u_out (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .cap_val(core_out), .si(oe_stage), .stage_q(out_stage)
            );

            // Sampled-input cell: nearest tdo within this pin.
            bsr_cell u_in (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .cap_val(pad_in), .si(out_stage), .stage_q(so)
            );

            // Update latches: copy the stages on update, hold otherwise.
            always_ff @(posedge tck) begin
                if (!rst_n) begin
                    out_lat <= 1'b0;
                    oe_lat  <= 1'b0;
                end else if (upd_en) begin
                    out_lat <= out_stage;
                    oe_lat  <= oe_stage;
                end
            end

            // Pad mux: latches in test mode, core values otherwise.
            always_comb begin
                pad_out = extest ? out_lat : core_out;
                pad_oe  = extest ? oe_lat  : core_oe;
            end

            // R9: update copies the pre-edge stage contents
            a_r9_latch_load: assert property (@(posedge tck) disable iff (!rst_n)
                upd_en |=> (out_lat == $past(out_stage)) && (oe_lat == $past(oe_stage)));

            // R6: latches hold across edges without update
            a_r6_latch_hold: assert property (@(posedge tck) disable iff (!rst_n)
                !upd_en |=> $stable(out_lat) && $stable(oe_lat));
        end
    endgenerate

endmodule

// File: rtl/bscan_chain.sv
// Module: a boundary-scan data register over NUM_PINS pins.
// Pin 0 sits nearest tdo and pin NUM_PINS-1 nearest tdi.
// PIN_KINDS packs one bsr_pkg kind code per pin, with pin i at bits [2i+1:2i].
// Assumes the TAP controller supplies mutually timed strobes on tck.
module bscan_chain #(
    parameter int NUM_PINS = 5,
    parameter logic [NUM_PINS*bsr_pkg::KIND_W-1:0] PIN_KINDS =
        {2'd1, 2'd0, 2'd2, 2'd1, 2'd0}
) (
    input  logic                tck,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic                shf_en,
    input  logic                upd_en,
    input  logic                extest,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int KW = bsr_pkg::KIND_W;

    // Serial links between pin segments: link[NUM_PINS] is tdi, link[0] is tdo.
    logic [NUM_PINS:0] link;

    assign link[NUM_PINS] = tdi;
    assign tdo            = link[0];

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            bsr_pin #(.KIND(PIN_KINDS[KW*i +: KW])) u_pin (
                .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en),
                .upd_en(upd_en), .extest(extest),
                .si(link[i+1]), .so(link[i]),
                .pad_in(pad_in[i]), .core_out(core_out[i]), .core_oe(core_oe[i]),
                .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
            );
        end
    endgenerate

endmodule

// File: tb/bscan_chain_test.sv
`timescale 1ns/1ps
module bscan_chain_test;
    localparam int NP = 5;
    localparam logic [2*NP-1:0] KINDS = {2'd1, 2'd0, 2'd2, 2'd1, 2'd0};

    // Total register length from the kind list (R1).
    function automatic int chain_len();
        int n = 0;
        for (int i = 0; i < NP; i++) n += (KINDS[2*i +: 2] == 2'd1) ? 1 : 3;
        return n;
    endfunction
    localparam int N = chain_len();

    logic clk = 0, rst_n = 0, cap_en = 0, shf_en = 0, upd_en = 0, extest = 0, tdi = 0;
    logic tdo;
    logic [NP-1:0] pad_in = '0, core_out = '0, core_oe = '0, pad_out, pad_oe;

    int compared = 0, mismatched = 0;
    logic  exp_q[$];
    string tag_q[$];
    logic  mon_en = 0;
    bit    done = 0;

    bscan_chain uut (
        .tck(clk), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
        .extest(extest), .tdi(tdi), .tdo(tdo), .pad_in(pad_in), .core_out(core_out),
        .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #2 clk = ~clk;

    // Monitor: pops one expected tdo bit per shifted cycle and compares.
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            logic e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (tdo !== e) begin
                mismatched++;
                $display("FAIL %s tdo stream: actual %0b expected %0b", t, tdo, e);
            end
        end
    end

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Bit offset of each pin within the register (R2).
    function automatic int base_of(input int p);
        int b = 0;
        for (int i = 0; i < p; i++) b += (KINDS[2*i +: 2] == 2'd1) ? 1 : 3;
        return b;
    endfunction

    function automatic logic is_in_only(input int p);
        return KINDS[2*p +: 2] == 2'd1;
    endfunction

    // Expected register contents after a capture (R2, R4).
    function automatic logic [N-1:0] cap_image(input logic [NP-1:0] pi, co, ce);
        logic [N-1:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            v[base_of(p)] = pi[p];
            if (!is_in_only(p)) begin
                v[base_of(p)+1] = co[p];
                v[base_of(p)+2] = ce[p];
            end
        end
        return v;
    endfunction

    // Checks the pads against a latch image while in test mode (R3, R7).
    task automatic check_pads(input string tag, input logic [N-1:0] lat);
        logic [NP-1:0] eo = '0, ee = '0;
        for (int p = 0; p < NP; p++)
            if (!is_in_only(p)) begin
                eo[p] = lat[base_of(p)+1];
                ee[p] = lat[base_of(p)+2];
            end
        check({tag, " pad_out"}, pad_out, eo);
        check({tag, " pad_oe"}, pad_oe, ee);
    endtask

    // Driver: shifts din in (LSB first) while queuing the expected stream out.
    task automatic shift_vec(input logic [N-1:0] din, input logic [N-1:0] exp, input string tag);
        for (int j = 0; j < N; j++) begin
            @(posedge clk); #1;
            shf_en = 1; tdi = din[j]; mon_en = 1;
            exp_q.push_back(exp[j]); tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        shf_en = 0; mon_en = 0; tdi = 0;
    endtask

    task automatic pulse(input logic c, input logic s, input logic u);
        @(posedge clk); #1;
        cap_en = c; shf_en = s; upd_en = u;
        @(posedge clk); #1;
        cap_en = 0; shf_en = 0; upd_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    localparam logic [N-1:0] V = 11'b10110011101;
    localparam logic [N-1:0] W = 11'b01101100110;
    localparam logic [N-1:0] X = 11'b11100101001;
    localparam logic [N-1:0] Y = 11'b00111010110;
    localparam logic [N-1:0] Z = 11'b10011110001;
    localparam logic [NP-1:0] DRV = 5'b01101; // pins that can drive

    initial begin
        // R10: reset state
        extest = 1;
        repeat (2) @(posedge clk);
        #1;
        check("R10 tdo", {4'b0, tdo}, 5'b0);
        check_pads("R10 reset latches", '0);
        rst_n = 1; extest = 0;

        // R7 and R3: normal mode passes core values, input-only pins stay off
        core_out = 5'b10111; core_oe = 5'b11011;
        #1;
        check("R7 R3 normal pad_out", pad_out, core_out & DRV);
        check("R7 R3 normal pad_oe", pad_oe, core_oe & DRV);

        // R10 / R5: stages are clear after reset; preload V
        shift_vec(V, '0, "R10 cleared stages");
        pulse(0, 0, 1);
        extest = 1; #1;
        check_pads("R7 R3 extest from latches", V);

        // R5 and R6: shifting streams V out in order while latches hold
        shift_vec(W, V, "R5 shift order");
        check_pads("R6 latches hold during shift", V);

        // R8: capture and shift together; R4 and R2: capture layout
        pad_in = 5'b10110; core_out = 5'b01011; core_oe = 5'b11001;
        pulse(1, 1, 0);
        shift_vec(X, cap_image(5'b10110, 5'b01011, 5'b11001), "R8 R4 R2 capture");
        // R1: exactly N shifts from tdi to tdo
        shift_vec(Y, X, "R1 length");

        // R9: capture and update on one edge
        pad_in = 5'b01001; core_out = 5'b10100; core_oe = 5'b00110;
        pulse(1, 0, 1);
        #1;
        check_pads("R9 latches took pre-edge stages", Y);
        // R11: idle edges leave the stages alone
        repeat (3) @(posedge clk);
        shift_vec(Z, cap_image(5'b01001, 5'b10100, 5'b00110), "R9 R11 captured stages");
        shift_vec('0, Z, "R5 second stream");

        // R10: mid-run reset clears latches and stages
        @(posedge clk); #1; rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        check_pads("R10 mid-run reset", '0);
        check("R10 tdo after reset", {4'b0, tdo}, 5'b0);
        @(posedge clk); #1;
        check("R3 scoreboard drained", 5'(exp_q.size()), 5'b0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule